// File: doc/BRIEF.md
# Change-of-State Digital Input Port

This block is a bus-attached input peripheral. It watches 48 digital input lines, organised as six groups of eight, and presents their synchronised levels through six byte-wide data registers. Each group can be armed to detect a change of level. While armed, any rising or falling transition on any of its eight lines marks the group as pending. While any group is pending, the block holds an active-high interrupt request.

Software talks to the block over a byte bus. The bus has a 3-bit address, a chip select, a read strobe and a write strobe. The data groups sit at offsets 0, 1, 2, 4, 5 and 6. Offset 3 is an unused hole. Offset 7 is shared: a write stores the six group arm bits, and a read returns the pending flags together with an active-low summary bit. Reading offset 7 acknowledges every pending flag in one step.

Top module: `cos_input_port`

## Requirements
- R1: After reset the read data is 0x00, the interrupt is low, and a status read returns 0x40, because nothing is pending and bit 6 is 1.
- R2: A read of offset 0, 1, 2, 4, 5 or 6 returns group 0 to 5 respectively. Bit n of group g holds the synchronised level of line g*8+n.
- R3: A read of offset 3 returns 0x00, and bit 7 of the status byte is always 0.
- R4: A write to offset 7 stores wdata bits 5:0 as the arm mask, with bit g arming group g. Writes to any other offset change nothing.
- R5: For an armed group, a rising edge and a falling edge on any of its lines both set the group's pending flag. The flag sets on the third rising clock edge after the input changes: two synchroniser stages, then one edge-detect register.
- R6: A change on a group whose arm bit is 0 never sets its flag. With a mask of all zeros, the interrupt never asserts.
- R7: Writing a 0 to a group's arm bit clears that group's pending flag one cycle after the write.
- R8: A status read at offset 7 returns the pending flags in bits 5:0 and returns bit 6 = 0 when any flag is pending. The same clock edge clears all flags and drops the interrupt.
- R9: A change that would set a flag on the same edge as a status read keeps that flag set.
- R10: The interrupt output is a register. It is high exactly when at least one pending flag is set.
- R11: Read data is registered. It updates on the clock edge that samples cs_i and rd_i both high, and holds its value at all other times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select |
| rd_i | input | 1 | Read strobe, qualified by cs_i |
| wr_i | input | 1 | Write strobe, qualified by cs_i |
| addr_i | input | 3 | Byte offset |
| wdata_i | input | 8 | Write data |
| lines_i | input | 48 | Asynchronous input lines |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Active-high interrupt request |

## Verification
The bench builds the block with its default parameters: eight-bit groups and a two-stage synchroniser. Under these values, the three-cycle change-to-flag latency is short enough to check edge by edge. That latency also makes it possible to line up a fresh change with a status read on exactly the same clock edge. Random traffic mixes line flips with arm-mask writes and reads of every offset, including the hole at offset 3. As a result, arming, disarming, acknowledging and reading data all collide in many different orders.

// File: rtl/cos_pkg.sv
package cos_pkg;
  localparam int NUM_GROUPS = 6;
  localparam int ADDR_W     = 3;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = 3'd7;

  // data groups skip offset 3: groups 0..2 at 0..2, groups 3..5 at 4..6
  function automatic logic [ADDR_W-1:0] group_addr(input int g);
    return (g < 3) ? ADDR_W'(g) : ADDR_W'(g + 1);
  endfunction
endpackage

// File: rtl/cos_sync.sv
module cos_sync #(
  parameter int W      = 48,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cos_group_detect.sv
module cos_group_detect #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] smp_i,
  input  logic         arm_i,
  input  logic         ack_i,
  output logic         chg_o,
  output logic         pend_nxt_o,
  output logic         pend_o
);
  logic [W-1:0] prev_q;
  logic         pend_q;

  assign chg_o = |(smp_i ^ prev_q);

  // priority: disarm clears, change sets, acknowledge clears
  always_comb begin
    pend_nxt_o = pend_q;
    if (!arm_i)      pend_nxt_o = 1'b0;
    else if (chg_o)  pend_nxt_o = 1'b1;
    else if (ack_i)  pend_nxt_o = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= smp_i;
      pend_q <= pend_nxt_o;
    end
  end

  assign pend_o = pend_q;

  assert_set_on_change_R5: assert property (@(posedge clk) disable iff (rst)
    (arm_i && chg_o) |=> pend_q);
  assert_disarm_clears_R7: assert property (@(posedge clk) disable iff (rst)
    !arm_i |=> !pend_q);
  assert_no_set_disarmed_R6: assert property (@(posedge clk) disable iff (rst)
    (!pend_q && !arm_i) |=> !pend_q);
endmodule

// File: rtl/cos_bus_regs.sv
module cos_bus_regs
  import cos_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cs_i,
  input  logic                    rd_i,
  input  logic                    wr_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [W-1:0]            wdata_i,
  input  logic [NUM_GROUPS*W-1:0] grp_data_i,
  input  logic [NUM_GROUPS-1:0]   pend_i,
  output logic [NUM_GROUPS-1:0]   arm_o,
  output logic                    ack_o,
  output logic [W-1:0]            rdata_o
);
  // status layout needs bit NUM_GROUPS (summary) inside the data byte
  localparam int SUM_BIT = NUM_GROUPS;

  logic [NUM_GROUPS-1:0] hit;
  logic [NUM_GROUPS-1:0] arm_q;
  logic [W-1:0]          rdata_q, rdata_nxt, status;
  logic                  rd_en, wr_ctrl;

  assign rd_en   = cs_i && rd_i;
  assign wr_ctrl = cs_i && wr_i && (addr_i == CTRL_ADDR);
  assign ack_o   = rd_en && (addr_i == CTRL_ADDR);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_dec
    assign hit[g] = (addr_i == group_addr(g));
  end

  always_comb begin
    status = '0;
    status[NUM_GROUPS-1:0] = pend_i;
    status[SUM_BIT] = ~|pend_i;
  end

  always_comb begin
    rdata_nxt = rdata_q;
    if (rd_en) begin
      rdata_nxt = '0;
      if (addr_i == CTRL_ADDR) rdata_nxt = status;
      for (int g = 0; g < NUM_GROUPS; g++)
        if (hit[g]) rdata_nxt = grp_data_i[g*W +: W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_q   <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_ctrl) arm_q <= wdata_i[NUM_GROUPS-1:0];
      rdata_q <= rdata_nxt;
    end
  end

  assign arm_o   = arm_q;
  assign rdata_o = rdata_q;

  assert_hole_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr_i == 3'd3) |=> (rdata_q == '0));
  assert_status_bit7_R3: assert property (@(posedge clk) disable iff (rst)
    ack_o |=> (rdata_q[W-1] == 1'b0));
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata_q));
  assert_arm_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !wr_ctrl |=> $stable(arm_q));
endmodule

// File: rtl/cos_input_port.sv
module cos_input_port
  import cos_pkg::*;
#(
  parameter int GROUP_W     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cs_i,
  input  logic                          rd_i,
  input  logic                          wr_i,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [GROUP_W-1:0]            wdata_i,
  input  logic [NUM_GROUPS*GROUP_W-1:0] lines_i,
  output logic [GROUP_W-1:0]            rdata_o,
  output logic                          irq_o
);
  localparam int LINES = NUM_GROUPS * GROUP_W;

  logic [LINES-1:0]      smp;
  logic [NUM_GROUPS-1:0] arm, chg, pend, pend_nxt;
  logic                  ack;
  logic                  irq_q;

  cos_sync #(.W(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (lines_i),
    .q_o (smp)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    cos_group_detect #(.W(GROUP_W)) u_det (
      .clk        (clk),
      .rst        (rst),
      .smp_i      (smp[g*GROUP_W +: GROUP_W]),
      .arm_i      (arm[g]),
      .ack_i      (ack),
      .chg_o      (chg[g]),
      .pend_nxt_o (pend_nxt[g]),
      .pend_o     (pend[g])
    );
  end

  cos_bus_regs #(.W(GROUP_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .cs_i       (cs_i),
    .rd_i       (rd_i),
    .wr_i       (wr_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .grp_data_i (smp),
    .pend_i     (pend),
    .arm_o      (arm),
    .ack_o      (ack),
    .rdata_o    (rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |pend_nxt;
  end

  assign irq_o = irq_q;

  assert_irq_tracks_R10: assert property (@(posedge clk) disable iff (rst)
    irq_q == (|pend));
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (ack && !(|(chg & arm))) |=> (pend == '0) && !irq_q);
  assert_ack_keeps_new_R9: assert property (@(posedge clk) disable iff (rst)
    (ack && |(chg & arm)) |=> irq_q);
endmodule

// File: tb/cos_input_port_tb.sv
module cos_input_port_tb;
  localparam int  W  = 8;
  localparam int  NG = 6;
  localparam int  NL = NG * W;
  localparam time CLK_P = 20ns;

  logic          clk = 0, rst = 1;
  logic          cs = 0, rd = 0, wr = 0;
  logic [2:0]    addr = '0;
  logic [W-1:0]  wdata = '0;
  logic [NL-1:0] lines = '0;
  logic [W-1:0]  rdata;
  logic          irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  cos_input_port u_dut (
    .clk(clk), .rst(rst), .cs_i(cs), .rd_i(rd), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .lines_i(lines), .rdata_o(rdata), .irq_o(irq)
  );

  // reference model derived from the requirements
  logic [NL-1:0] m_s1, m_s2, m_prev;
  logic [NG-1:0] m_arm, m_pend;
  logic [W-1:0]  m_rdata;
  logic          m_irq;

  function automatic int grp_of(input logic [2:0] a);
    return (a < 3) ? int'(a) : int'(a) - 1;
  endfunction

  always @(posedge clk) begin
    logic [NG-1:0] pn;
    logic ackm;
    if (rst) begin
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_arm <= '0;
      m_pend <= '0; m_rdata <= '0; m_irq <= 0;
    end else begin
      ackm = cs && rd && addr == 3'd7;
      for (int g = 0; g < NG; g++) begin
        if (!m_arm[g]) pn[g] = 0;
        else if (m_s2[g*W +: W] != m_prev[g*W +: W]) pn[g] = 1;
        else if (ackm) pn[g] = 0;
        else pn[g] = m_pend[g];
      end
      if (cs && rd) begin
        if (addr == 3'd7)      m_rdata <= {1'b0, ~|m_pend, m_pend};
        else if (addr == 3'd3) m_rdata <= '0;
        else                   m_rdata <= m_s2[grp_of(addr)*W +: W];
      end
      if (cs && wr && addr == 3'd7) m_arm <= wdata[NG-1:0];
      m_s1 <= lines; m_s2 <= m_s1; m_prev <= m_s2;
      m_pend <= pn; m_irq <= |pn;
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic bus_read(input logic [2:0] a, output logic [W-1:0] d);
    cs = 1; rd = 1; addr = a; tick(); cs = 0; rd = 0; d = rdata;
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [W-1:0] v);
    cs = 1; wr = 1; addr = a; wdata = v; tick(); cs = 0; wr = 0;
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    report();
  end

  initial begin
    logic [W-1:0] d;
    logic [W-1:0] held;
    void'($urandom(32'd20240611));
    @(negedge clk); tick(); tick(); rst = 0; tick();

    // R1 reset state
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 irq", {7'd0, irq}, 8'h00);
    bus_read(3'd7, d); chk("R1 status", d, 8'h40);

    // R2 group map and bit order
    lines = 48'hA5_3C_0F_81_7E_12;
    tick(); tick(); tick();
    bus_read(3'd0, d); chk("R2 g0", d, 8'h12);
    bus_read(3'd1, d); chk("R2 g1", d, 8'h7E);
    bus_read(3'd2, d); chk("R2 g2", d, 8'h81);
    bus_read(3'd4, d); chk("R2 g3", d, 8'h0F);
    bus_read(3'd5, d); chk("R2 g4", d, 8'h3C);
    bus_read(3'd6, d); chk("R2 g5", d, 8'hA5);
    bus_read(3'd3, d); chk("R3 hole", d, 8'h00);

    // R11 hold without read
    held = rdata; lines = ~lines; tick(); tick(); tick();
    chk("R11 hold", rdata, held);
    lines = '0; tick(); tick(); tick();

    // R5 latency on rising edge, group 2
    bus_write(3'd7, 8'h04);
    lines[17] = 1;
    tick(); tick(); chk("R5 not yet", {7'd0, irq}, 8'h00);
    tick(); chk("R5 rise", {7'd0, irq}, 8'h01);
    chk("R10 irq with pending", {7'd0, irq}, 8'h01);
    bus_read(3'd7, d); chk("R8 status", d, 8'h04);
    chk("R3 bit7", {7'd0, d[7]}, 8'h00);
    chk("R8 irq cleared", {7'd0, irq}, 8'h00);
    lines[17] = 0;
    tick(); tick(); tick(); chk("R5 fall", {7'd0, irq}, 8'h01);
    bus_read(3'd7, d); chk("R8 status fall", d, 8'h04);

    // R6 disarmed group ignored
    lines[0] = 1; tick(); tick(); tick(); tick();
    chk("R6 disarmed", {7'd0, irq}, 8'h00);
    bus_read(3'd7, d); chk("R6 status", d, 8'h40);
    bus_write(3'd7, 8'h00);
    lines = ~lines; tick(); tick(); tick(); tick();
    chk("R6 all off", {7'd0, irq}, 8'h00);

    // R4 writes to other offsets ignored
    bus_write(3'd0, 8'hFF); bus_write(3'd3, 8'hFF);
    lines = ~lines; tick(); tick(); tick(); tick();
    chk("R4 other offset", {7'd0, irq}, 8'h00);
    bus_write(3'd7, 8'hC1);  // upper bits discarded, group 0 armed
    lines[1] = ~lines[1]; tick(); tick(); tick();
    bus_read(3'd7, d); chk("R4 mask", d, 8'h01);

    // R7 disarm clears pending
    lines[2] = ~lines[2]; tick(); tick(); tick();
    chk("R7 pending", {7'd0, irq}, 8'h01);
    bus_write(3'd7, 8'h00); tick();
    chk("R7 cleared", {7'd0, irq}, 8'h00);
    bus_write(3'd7, 8'h01); tick();
    bus_read(3'd7, d); chk("R7 status", d, 8'h40);

    // R9 change coincides with acknowledge
    bus_write(3'd7, 8'h02);
    lines[8] = ~lines[8]; tick(); tick();
    bus_read(3'd7, d);
    chk("R9 old status", d, 8'h40);
    chk("R9 kept", {7'd0, irq}, 8'h01);
    bus_read(3'd7, d); chk("R9 status", d, 8'h02);

    // random phase against model
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom % 10;
      if ($urandom % 3 == 0)
        lines[($urandom % NG)*W +: W] ^= 8'($urandom);
      cs = 0; rd = 0; wr = 0;
      if (op < 4) begin cs = 1; rd = 1; addr = 3'($urandom); end
      else if (op == 4) begin cs = 1; rd = 1; addr = 3'd7; end
      else if (op == 5) begin cs = 1; wr = 1; addr = 3'($urandom); wdata = 8'($urandom); end
      tick();
      cs = 0; rd = 0; wr = 0;
      if (addr == 3'd7) chk("R8 random status/data", rdata, m_rdata);
      else if (addr == 3'd3) chk("R3 random", rdata, m_rdata);
      else chk("R2 random data", rdata, m_rdata);
      chk("R10 random irq", {7'd0, irq}, {7'd0, m_irq});
    end

    done = 1;
    report();
  end
endmodule